// File: doc/BRIEF.md
# Two-Level Context Page Translator

This block turns a virtual address into a physical page number by walking two tables held inside it. The current context and the upper address bits pick a segment slot, and that slot names one group of sixteen page descriptors out of a shared pool. The address bits just above the 8 KiB byte offset then pick the descriptor within the group. The descriptor gives the physical page, a page type, a valid flag and a two-bit access code. The access code combines a write-enable bit with a supervisor-only bit.

A translation request carries the address, a write flag and a supervisor flag. One cycle later the block answers with the page number, the type and a fault flag. A permitted access marks the descriptor as referenced, and a permitted write also marks it as dirty. That write-back lands on the same clock edge as the answer. A denied access leaves the descriptor unchanged. A small configuration port loads the context register, the segment slots and the descriptors, and reads them back. It addresses the tables the way a translation does, through the current context.

The default parameters give a reduced virtual space so that the tables stay small when elaborated. Setting `VA_BITS` to 28 and `PMEG_BITS` to 8 gives eight contexts of 256 MiB, with 2048 segment slots per context and a pool of 256 groups.

Top module: `mmu_translator`

## Requirements
- R1: The context register keeps only the low `CTX_BITS` bits of a write and ignores the upper bits. A read of it returns those bits zero-extended to 32 bits.
- R2: A translation uses the segment slot at index {context, address bits [VA_BITS-1:17]}. The same address under two contexts can therefore reach two different groups.
- R3: The descriptor used sits at index {segment slot value, address bits [16:13]}. Its bits [18:0] give the page number output and its bits [28:26] give the type output.
- R4: A descriptor whose valid bit (bit 31) is 0 makes the translation fault.
- R5: The access code is descriptor bits [30:29]. Bit 30 set allows writes. Bit 29 set forbids user (non-supervisor) accesses. A write to a code without bit 30, or a user access to a code with bit 29, faults.
- R6: A permitted read sets the referenced bit (bit 25). A permitted write sets both bit 25 and the dirty bit (bit 24). Every other descriptor bit is kept. The next access and a read-back both see the change.
- R7: A faulting access leaves the whole descriptor unchanged and drives the page and type outputs to zero.
- R8: `rspValid` is high exactly in the cycle after an accepted request.
- R9: `cfgSel` chooses the target: 0 is the context register, 1 is a segment slot (low `PMEG_BITS` bits of the data), 2 is a descriptor (all 32 bits), and 3 is nothing. A write to 3 changes nothing and a read of 3 returns 0. A read returns its data one cycle later with `cfgRdValid` high.
- R10: When `cfgEn` and `reqValid` are both high in the same cycle, the configuration access is served and the translation request is dropped. No response follows and no descriptor bit changes.
- R11: After reset the context is 0 and both `rspValid` and `cfgRdValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | VA_BITS | Virtual address to translate |
| reqWrite | input | 1 | Request is a write |
| reqSuper | input | 1 | Request is made in supervisor state |
| rspValid | output | 1 | Translation response valid |
| rspPage | output | 19 | Physical page number (0 on fault) |
| rspType | output | 3 | Page type (0 on fault) |
| rspFault | output | 1 | Access denied or descriptor invalid |
| cfgEn | input | 1 | Configuration access strobe |
| cfgWrite | input | 1 | Configuration access is a write |
| cfgSel | input | 2 | Target: 0 context, 1 segment slot, 2 descriptor, 3 none |
| cfgAddr | input | VA_BITS | Virtual address locating the segment slot or descriptor |
| cfgData | input | 32 | Configuration write data |
| cfgRdValid | output | 1 | Configuration read data valid |
| cfgRdData | output | 32 | Configuration read data |

## Verification
The assertions assume that the inputs are driven to known values whenever the block is out of reset. They also assume that software loads a descriptor before any translation reaches it. The bench keeps within these limits. It drives every input at the falling edge, and before it translates anything it fills every group of the pool and every segment slot of every context through the configuration port. The random phase draws addresses, contexts, access codes and request flags from the whole of that loaded space. The directed part covers each combination of access code, privilege and direction, invalid descriptors, context writes with junk upper bits, the unused select code, and a translation request that collides with a configuration access.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  localparam int PAGE_SHIFT      = 13;
  localparam int GROUP_PAGE_BITS = 4;
  localparam int PPN_BITS        = 19;
  localparam int ENTRY_BITS      = 32;

  localparam int BIT_VALID = 31;
  localparam int BIT_WREN  = 30;
  localparam int BIT_SUPO  = 29;
  localparam int TYPE_LSB  = 26;
  localparam int BIT_REF   = 25;
  localparam int BIT_DIRTY = 24;

  typedef enum logic [1:0] {
    SEL_CTX  = 2'd0,
    SEL_SEG  = 2'd1,
    SEL_PAGE = 2'd2,
    SEL_NONE = 2'd3
  } cfgTarget_t;

  typedef struct packed {
    logic ctxWr;
    logic segWr;
    logic pageWr;
    logic rdLoad;
    logic xlate;
  } mmuStrobes_t;

endpackage

// File: rtl/mmu_ctrl.sv
module mmu_ctrl
  import mmu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        cfgEn,
  input  logic        cfgWrite,
  input  logic [1:0]  cfgSel,
  output mmuStrobes_t strb,
  output logic        rspValid,
  output logic        cfgRdValid
);

  logic cfgWr;
  cfgTarget_t target;

  always_comb begin
    target      = cfgTarget_t'(cfgSel);
    cfgWr       = cfgEn && cfgWrite;
    strb.ctxWr  = cfgWr && (target == SEL_CTX);
    strb.segWr  = cfgWr && (target == SEL_SEG);
    strb.pageWr = cfgWr && (target == SEL_PAGE);
    strb.rdLoad = cfgEn && !cfgWrite;
    // a configuration access wins over a translation in the same cycle
    strb.xlate  = reqValid && !cfgEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      cfgRdValid <= 1'b0;
    end else begin
      rspValid   <= strb.xlate;
      cfgRdValid <= strb.rdLoad;
    end
  end

endmodule

// File: rtl/mmu_datapath.sv
module mmu_datapath
  import mmu_pkg::*;
#(
  parameter int VA_BITS   = 20,
  parameter int CTX_BITS  = 3,
  parameter int PMEG_BITS = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  mmuStrobes_t         strb,
  input  logic [VA_BITS-1:0]  reqAddr,
  input  logic                reqWrite,
  input  logic                reqSuper,
  input  logic [VA_BITS-1:0]  cfgAddr,
  input  logic [31:0]         cfgData,
  input  logic [1:0]          cfgSel,
  output logic [PPN_BITS-1:0] rspPage,
  output logic [2:0]          rspType,
  output logic                rspFault,
  output logic [31:0]         cfgRdData
);

  localparam int SEG_BITS     = VA_BITS - PAGE_SHIFT - GROUP_PAGE_BITS;
  localparam int SEG_IDX_BITS = CTX_BITS + SEG_BITS;
  localparam int PG_IDX_BITS  = PMEG_BITS + GROUP_PAGE_BITS;
  localparam int SEG_ENTRIES  = 1 << SEG_IDX_BITS;
  localparam int PG_ENTRIES   = 1 << PG_IDX_BITS;

  logic [CTX_BITS-1:0]   ctxReg;
  logic [PMEG_BITS-1:0]  segMap  [SEG_ENTRIES];
  logic [ENTRY_BITS-1:0] pageMap [PG_ENTRIES];

  logic [VA_BITS-1:0]      lookAddr;
  logic [SEG_IDX_BITS-1:0] segIdx;
  logic [PMEG_BITS-1:0]    groupSel;
  logic [PG_IDX_BITS-1:0]  pageIdx;
  logic [ENTRY_BITS-1:0]   entry;
  logic [ENTRY_BITS-1:0]   touched;
  logic                    denied;
  logic                    unusedOffset;

  assign unusedOffset = ^{reqAddr[PAGE_SHIFT-1:0], cfgAddr[PAGE_SHIFT-1:0]};

  // two-level walk: context + segment field -> group, group + page field -> entry
  always_comb begin
    lookAddr = strb.xlate ? reqAddr : cfgAddr;
    segIdx   = {ctxReg, lookAddr[VA_BITS-1 -: SEG_BITS]};
    groupSel = segMap[segIdx];
    pageIdx  = {groupSel, lookAddr[PAGE_SHIFT +: GROUP_PAGE_BITS]};
    entry    = pageMap[pageIdx];
  end

  // protection: invalid, user on supervisor-only, or write to read-only
  always_comb begin
    denied = !entry[BIT_VALID]
          || (entry[BIT_SUPO] && !reqSuper)
          || (reqWrite && !entry[BIT_WREN]);
    touched = entry;
    touched[BIT_REF] = 1'b1;
    if (reqWrite) touched[BIT_DIRTY] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.segWr) segMap[segIdx] <= cfgData[PMEG_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.pageWr) begin
      pageMap[pageIdx] <= cfgData;
    end else if (strb.xlate && !denied) begin
      pageMap[pageIdx] <= touched;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctxReg    <= '0;
      rspPage   <= '0;
      rspType   <= '0;
      rspFault  <= 1'b0;
      cfgRdData <= '0;
    end else begin
      if (strb.ctxWr) ctxReg <= cfgData[CTX_BITS-1:0];
      if (strb.xlate) begin
        rspFault <= denied;
        rspPage  <= denied ? '0 : entry[PPN_BITS-1:0];
        rspType  <= denied ? '0 : entry[TYPE_LSB +: 3];
      end
      if (strb.rdLoad) begin
        unique case (cfgTarget_t'(cfgSel))
          SEL_CTX:  cfgRdData <= 32'(ctxReg);
          SEL_SEG:  cfgRdData <= 32'(groupSel);
          SEL_PAGE: cfgRdData <= entry;
          default:  cfgRdData <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/mmu_translator.sv
module mmu_translator
  import mmu_pkg::*;
#(
  parameter int VA_BITS   = 20,
  parameter int CTX_BITS  = 3,
  parameter int PMEG_BITS = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [VA_BITS-1:0]  reqAddr,
  input  logic                reqWrite,
  input  logic                reqSuper,
  output logic                rspValid,
  output logic [18:0]         rspPage,
  output logic [2:0]          rspType,
  output logic                rspFault,
  input  logic                cfgEn,
  input  logic                cfgWrite,
  input  logic [1:0]          cfgSel,
  input  logic [VA_BITS-1:0]  cfgAddr,
  input  logic [31:0]         cfgData,
  output logic                cfgRdValid,
  output logic [31:0]         cfgRdData
);

  mmuStrobes_t strb;

  mmu_ctrl ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cfgEn(cfgEn),
    .cfgWrite(cfgWrite), .cfgSel(cfgSel), .strb(strb),
    .rspValid(rspValid), .cfgRdValid(cfgRdValid)
  );

  mmu_datapath #(.VA_BITS(VA_BITS), .CTX_BITS(CTX_BITS), .PMEG_BITS(PMEG_BITS)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSuper(reqSuper), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .cfgSel(cfgSel), .rspPage(rspPage),
    .rspType(rspType), .rspFault(rspFault), .cfgRdData(cfgRdData)
  );

endmodule

// File: rtl/mmu_translator_chk.sv
module mmu_translator_chk #(
  parameter int VA_BITS   = 20,
  parameter int CTX_BITS  = 3,
  parameter int PMEG_BITS = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [VA_BITS-1:0] reqAddr,
  input logic               reqWrite,
  input logic               reqSuper,
  input logic               rspValid,
  input logic [18:0]        rspPage,
  input logic [2:0]         rspType,
  input logic               rspFault,
  input logic               cfgEn,
  input logic               cfgWrite,
  input logic [1:0]         cfgSel,
  input logic [VA_BITS-1:0] cfgAddr,
  input logic [31:0]        cfgData,
  input logic               cfgRdValid,
  input logic [31:0]        cfgRdData
);

  assert_rsp_after_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cfgEn) |=> rspValid);

  assert_no_rsp_without_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_collision_drops_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cfgEn) |=> !rspValid);

  assert_fault_blanks_outputs_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspPage == 19'd0 && rspType == 3'd0));

  assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEn && !cfgWrite) |=> cfgRdValid);

  assert_no_stray_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgEn && !cfgWrite) |=> !cfgRdValid);

  assert_none_reads_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEn && !cfgWrite && cfgSel == 2'd3) |=> (cfgRdData == 32'd0));

  assert_ctx_upper_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEn && !cfgWrite && cfgSel == 2'd0) |=> ((cfgRdData >> CTX_BITS) == 32'd0));

endmodule

bind mmu_translator mmu_translator_chk #(
  .VA_BITS(VA_BITS), .CTX_BITS(CTX_BITS), .PMEG_BITS(PMEG_BITS)
) chk (.*);

// File: tb/mmu_translator_test.sv
module mmu_translator_test;

  localparam int VA   = 20;
  localparam int CTXB = 3;
  localparam int PMB  = 5;
  localparam int NSEG = 1 << (CTXB + VA - 17);
  localparam int NPG  = 1 << (PMB + 4);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqSuper = 1'b0;
  logic [VA-1:0] reqAddr = '0;
  logic rspValid, rspFault, cfgRdValid;
  logic [18:0] rspPage;
  logic [2:0] rspType;
  logic cfgEn = 1'b0, cfgWrite = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [VA-1:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [31:0] cfgRdData;

  int total = 0;
  int failed = 0;

  logic [CTXB-1:0] refCtx;
  logic [PMB-1:0]  refSeg [NSEG];
  logic [31:0]     refPage [NPG];

  always #4 clk = ~clk;

  mmu_translator #(.VA_BITS(VA), .CTX_BITS(CTXB), .PMEG_BITS(PMB)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSuper(reqSuper), .rspValid(rspValid),
    .rspPage(rspPage), .rspType(rspType), .rspFault(rspFault),
    .cfgEn(cfgEn), .cfgWrite(cfgWrite), .cfgSel(cfgSel), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .cfgRdValid(cfgRdValid), .cfgRdData(cfgRdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic int segIndex(input logic [VA-1:0] a);
    return int'({refCtx, a[VA-1:17]});
  endfunction

  function automatic int pageIndex(input logic [VA-1:0] a);
    return int'({refSeg[segIndex(a)], a[16:13]});
  endfunction

  function automatic logic isDenied(input logic [31:0] e, input logic wr, input logic sup);
    return !e[31] || (e[29] && !sup) || (wr && !e[30]);
  endfunction

  task automatic cfgWr(input logic [1:0] sel, input logic [VA-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgEn = 1'b1; cfgWrite = 1'b1; cfgSel = sel; cfgAddr = a; cfgData = d;
    case (sel)
      2'd0: refCtx = d[CTXB-1:0];
      2'd1: refSeg[segIndex(a)] = d[PMB-1:0];
      2'd2: refPage[pageIndex(a)] = d;
      default: ;
    endcase
    @(negedge clk);
    cfgEn = 1'b0; cfgWrite = 1'b0;
  endtask

  task automatic cfgRd(input logic [1:0] sel, input logic [VA-1:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    cfgEn = 1'b1; cfgWrite = 1'b0; cfgSel = sel; cfgAddr = a;
    case (sel)
      2'd0: exp = 32'(refCtx);
      2'd1: exp = 32'(refSeg[segIndex(a)]);
      2'd2: exp = refPage[pageIndex(a)];
      default: exp = 32'd0;
    endcase
    @(negedge clk);
    cfgEn = 1'b0;
    check({tag, " rdValid"}, 32'(cfgRdValid), 32'd1);
    check({tag, " rdData"}, cfgRdData, exp);
  endtask

  task automatic xlate(input logic [VA-1:0] a, input logic wr, input logic sup, input string tag);
    logic [31:0] e;
    logic den;
    int idx;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqSuper = sup;
    idx = pageIndex(a);
    e = refPage[idx];
    den = isDenied(e, wr, sup);
    if (!den) begin
      refPage[idx][25] = 1'b1;
      if (wr) refPage[idx][24] = 1'b1;
    end
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " rspValid"}, 32'(rspValid), 32'd1);
    check({tag, " fault"}, 32'(rspFault), 32'(den));
    check({tag, " page"}, 32'(rspPage), den ? 32'd0 : 32'(e[18:0]));
    check({tag, " type"}, 32'(rspType), den ? 32'd0 : 32'(e[28:26]));
  endtask

  function automatic logic [VA-1:0] mkAddr(input int seg, input int pg, input int off);
    logic [VA-1:0] a;
    a = '0;
    a[VA-1:17] = seg[VA-18:0];
    a[16:13] = pg[3:0];
    a[12:0] = off[12:0];
    return a;
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2718));
    refCtx = '0;
    repeat (3) @(negedge clk);
    // R11: state held in reset, then just after release
    check("R11 rspValid in reset", 32'(rspValid), 32'd0);
    check("R11 cfgRdValid in reset", 32'(cfgRdValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 rspValid after reset", 32'(rspValid), 32'd0);
    cfgRd(2'd0, '0, "R11 context after reset");

    // load every group through segment slot 0 of context 0
    for (int g = 0; g < (1 << PMB); g++) begin
      cfgWr(2'd1, '0, 32'(g));
      for (int p = 0; p < 16; p++) begin
        logic [31:0] d;
        d = $urandom;
        d[31] = ($urandom % 4) != 0;
        cfgWr(2'd2, mkAddr(0, p, 0), d);
      end
    end
    for (int c = 0; c < (1 << CTXB); c++) begin
      cfgWr(2'd0, '0, 32'(c));
      for (int s = 0; s < (1 << (VA - 17)); s++)
        cfgWr(2'd1, mkAddr(s, 0, 0), 32'($urandom % (1 << PMB)));
    end

    // R1: junk upper bits are dropped
    cfgWr(2'd0, '0, 32'hFFFF_FFF5);
    cfgRd(2'd0, '0, "R1 context masked");
    cfgWr(2'd0, '0, 32'h0000_0A02);
    cfgRd(2'd0, '0, "R1 context masked low");

    // R2: same address in two contexts mapped to distinct groups
    cfgWr(2'd0, '0, 32'd1);
    cfgWr(2'd1, mkAddr(2, 0, 0), 32'd3);
    cfgWr(2'd2, mkAddr(2, 5, 0), 32'h8000_0000 | (32'd1 << 26) | 32'h0_1111);
    cfgWr(2'd0, '0, 32'd2);
    cfgWr(2'd1, mkAddr(2, 0, 0), 32'd4);
    cfgWr(2'd2, mkAddr(2, 5, 0), 32'h8000_0000 | (32'd3 << 26) | 32'h0_2222);
    xlate(mkAddr(2, 5, 123), 1'b0, 1'b0, "R2 context 2");
    cfgWr(2'd0, '0, 32'd1);
    xlate(mkAddr(2, 5, 77), 1'b0, 1'b0, "R2 context 1");
    // R3: neighbouring page inside the same group
    cfgWr(2'd2, mkAddr(2, 6, 0), 32'h8000_0000 | (32'd4 << 26) | 32'h7_ABCD);
    xlate(mkAddr(2, 6, 8191), 1'b0, 1'b1, "R3 page field");

    // R5/R6/R7: every access code, privilege and direction
    for (int pc = 0; pc < 4; pc++)
      for (int sp = 0; sp < 2; sp++)
        for (int w = 0; w < 2; w++) begin
          cfgWr(2'd2, mkAddr(1, 9, 0),
                32'h8000_0000 | (32'(pc) << 29) | (32'd2 << 26) | 32'h0_0F00 | 32'(pc * 4 + sp * 2 + w));
          xlate(mkAddr(1, 9, 4), w[0], sp[0], "R5 access code");
          cfgRd(2'd2, mkAddr(1, 9, 0), "R6 R7 descriptor after access");
        end

    // R4: invalid descriptor with a permissive code
    cfgWr(2'd2, mkAddr(3, 1, 0), 32'h4000_1234);
    xlate(mkAddr(3, 1, 0), 1'b0, 1'b1, "R4 invalid");
    cfgRd(2'd2, mkAddr(3, 1, 0), "R4 R7 invalid untouched");

    // R6: read then write of one page, flags seen by the next access
    cfgWr(2'd2, mkAddr(3, 2, 0), 32'hC000_0000 | 32'h0_0042);
    xlate(mkAddr(3, 2, 0), 1'b0, 1'b1, "R6 read sets ref");
    cfgRd(2'd2, mkAddr(3, 2, 0), "R6 ref bit");
    xlate(mkAddr(3, 2, 0), 1'b1, 1'b1, "R6 write sets dirty");
    cfgRd(2'd2, mkAddr(3, 2, 0), "R6 dirty bit");

    // R9: unused select code
    cfgWr(2'd3, mkAddr(3, 2, 0), 32'hFFFF_FFFF);
    cfgRd(2'd3, mkAddr(3, 2, 0), "R9 none reads zero");
    cfgRd(2'd2, mkAddr(3, 2, 0), "R9 none write ignored");
    cfgRd(2'd1, mkAddr(3, 0, 0), "R9 segment read");

    // R10: request colliding with a configuration read
    cfgWr(2'd2, mkAddr(3, 3, 0), 32'h8000_0000 | 32'h0_0055);
    @(negedge clk);
    cfgEn = 1'b1; cfgWrite = 1'b0; cfgSel = 2'd2; cfgAddr = mkAddr(3, 3, 0);
    reqValid = 1'b1; reqAddr = mkAddr(3, 3, 0); reqWrite = 1'b0; reqSuper = 1'b1;
    @(negedge clk);
    cfgEn = 1'b0; reqValid = 1'b0;
    check("R10 request dropped", 32'(rspValid), 32'd0);
    check("R10 config served", cfgRdData, refPage[pageIndex(mkAddr(3, 3, 0))]);
    cfgRd(2'd2, mkAddr(3, 3, 0), "R10 no ref update");

    // random mix over the whole loaded space
    for (int i = 0; i < 3000; i++) begin
      int kind;
      logic [VA-1:0] a;
      a = VA'($urandom);
      kind = int'($urandom % 10);
      if (kind == 0) cfgWr(2'd0, '0, $urandom);
      else if (kind == 1) cfgWr(2'd1, a, 32'($urandom % (1 << PMB)));
      else if (kind == 2) begin
        logic [31:0] d;
        d = $urandom;
        d[31] = ($urandom % 4) != 0;
        cfgWr(2'd2, a, d);
      end
      else if (kind == 3) cfgRd(2'($urandom % 4), a, "R9 random read");
      else xlate(a, 1'($urandom), 1'($urandom), "R3 R5 R6 random");
    end

    finishRun();
  end

endmodule